// File: doc/BRIEF.md
# Fractional UART baud generator

This block derives the bit-rate timing for one serial channel from the system clock. A free-running prescaler offers four source rates. One of them is picked and divided by a 4-bit integer. An optional fractional term stretches some of the divided periods by one source tick. This lets the average ratio reach values between integers, so common baud rates can be produced from crystal frequencies that do not divide evenly.

In asynchronous (UART) mode, the divided rate is the 16x oversampling tick, and every sixteenth oversample tick marks a bit. In synchronous mode, the oversample output stays idle and a bit tick is issued once every two divided periods, which is one full cycle of a shift clock toggled on each divided tick. All outputs are single-cycle pulses in the system clock domain.

Top module: `uart_frac_baud`

## Requirements
- R1: While `rst_n` is low, `os_tick` and `bit_tick` are both 0.
- R2: `clk_sel` picks the source period P in system clocks: 0 gives 1, 1 gives 2, 2 gives 8 and 3 gives 32.
- R3: With the fraction off, the divided period is N·P clocks, where N is `div_n` and a value of 0 on `div_n` stands for 16.
- R4: `div_n` = 1 with the fraction off makes the divided tick follow the source exactly: one pulse every P clocks, which for P = 1 means every clock.
- R5: With `frac_en` = 1, each divided period is either N·P or (N+1)·P, and any 16 consecutive periods contain exactly 16−K long ones (K is `frac_k`), for a total of (16·N + 16 − K)·P clocks.
- R6: `frac_k` = 0 with `frac_en` = 1 is legal and makes every period (N+1)·P.
- R7: Long periods are spread evenly: when 16−K ≤ 8, two long periods never follow each other.
- R8: When `uart_mode` = 1, `os_tick` pulses once per divided period, and `bit_tick` pulses on every sixteenth `os_tick`, always in the same cycle as that `os_tick`.
- R9: When `uart_mode` = 0, `os_tick` stays 0 and `bit_tick` pulses once every two divided periods.
- R10: With `frac_en` = 0, the value of `frac_k` has no effect on any period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the base of the prescaler |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 2 | Source tap: 0 = /1, 1 = /2, 2 = /8, 3 = /32 |
| div_n | input | 4 | Integer divide ratio, 0 means 16 |
| frac_k | input | 4 | Fraction field; 16−K of every 16 periods are stretched |
| frac_en | input | 1 | Enables the fractional stretch |
| uart_mode | input | 1 | 1 = asynchronous with 16x oversampling, 0 = synchronous |
| os_tick | output | 1 | Oversampling tick pulse (UART mode only) |
| bit_tick | output | 1 | Bit-rate tick pulse |

## Verification
In UART mode, the bit tick and the sixteenth oversample tick come from the same divided pulse, so they must land in the same cycle. The bench runs a UART setting for many bit times and checks at every bit pulse that the oversample pulse is also high. The bit spacing must also be exactly sixteen oversample periods. In fractional mode, the end of a stretched period coincides with the accumulator update that picks the next period. This is judged by collecting sixteen consecutive periods and comparing both the per-period lengths and their sum against the N and K formula.

// File: rtl/baudgen_pkg.sv
// Package: shared constants and helpers for the fractional baud generator.
// Assumes four prescaler taps whose division ratios are powers of two.
package baudgen_pkg;
    localparam int TAP_COUNT = 4;   // number of selectable source taps
    localparam int DIV_W     = 4;   // width of the integer divide field
    localparam int FRAC_W    = 4;   // width of the fraction field
    localparam int OS_RATIO  = 16;  // oversample ticks per UART bit

    // log2 of the division ratio of each prescaler tap (1, 2, 8, 32)
    function automatic int tap_log2(input int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            2:       return 3;
            default: return 5;
        endcase
    endfunction

    localparam int PRE_W = tap_log2(TAP_COUNT - 1); // prescaler counter width
endpackage

// File: rtl/baud_prescale.sv
// Module: baud_prescale
// Free-running prescaler that produces a one-cycle source tick at the rate
// of the selected tap. Assumes tap ratios are powers of two, so each tap
// fires when the low bits of the counter are all ones.
module baud_prescale
    import baudgen_pkg::*;
#(
    parameter int NTAPS = TAP_COUNT,
    parameter int CW    = PRE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NTAPS)-1:0] tap_sel,
    output logic                     src_tick
);
    logic [CW-1:0]    pre_cnt;
    logic [NTAPS-1:0] tap_hit;

    // One hit detector per tap; tap 0 fires every cycle
    for (genvar gi = 0; gi < NTAPS; gi++) begin : g_tap
        localparam int L = tap_log2(gi);
        if (L == 0) begin : g_every
            assign tap_hit[gi] = 1'b1;
        end else begin : g_mask
            assign tap_hit[gi] = &pre_cnt[L-1:0];
        end
    end

    // Count system clocks and register the selected tap's hit as the source tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            src_tick <= 1'b0;
        end else begin
            pre_cnt  <= pre_cnt + 1'b1;
            src_tick <= tap_hit[tap_sel];
        end
    end

    // Slower taps are nested inside faster ones (R2)
    for (genvar gj = 1; gj < NTAPS; gj++) begin : g_nest_chk
        assert_tap_nested_R2: assert property (@(posedge clk) disable iff (!rst_n)
            tap_hit[gj] |-> tap_hit[gj-1]);
    end
endmodule

// File: rtl/baud_frac_div.sv
// Module: baud_frac_div
// Divides the source tick by N, or by N+1 on 16-K of every 16 periods when
// the fraction is enabled. An accumulator spreads the long periods evenly.
// Assumes the settings are static during normal running; a change
// mid-period only affects timing until the counter reaches its terminal.
module baud_frac_div
    import baudgen_pkg::*;
#(
    parameter int NW = DIV_W,
    parameter int KW = FRAC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_tick,
    input  logic [NW-1:0] div_n,
    input  logic [KW-1:0] frac_k,
    input  logic          frac_en,
    output logic          div_tick
);
    localparam int CNT_W = NW + 1;
    localparam int SUM_W = KW + 1;
    localparam logic [CNT_W-1:0] FULL_N   = CNT_W'(1 << NW);
    localparam logic [SUM_W-1:0] FRAC_MOD = SUM_W'(1 << KW);

    logic [CNT_W-1:0] cnt;
    logic [KW-1:0]    acc;
    logic             stretch;
    logic [CNT_W-1:0] base_n;
    logic [CNT_W-1:0] last_idx;
    logic [SUM_W-1:0] step;
    logic [SUM_W-1:0] sum;
    logic             terminal;

    // Period length for this period and the next accumulator value
    always_comb begin
        base_n   = (div_n == '0) ? FULL_N : {1'b0, div_n};
        last_idx = base_n + {{(CNT_W-1){1'b0}}, stretch} - CNT_W'(1);
        step     = FRAC_MOD - {1'b0, frac_k};
        sum      = {1'b0, acc} + step;
        terminal = (cnt >= last_idx);
    end

    // Count source ticks, emit the divided tick and pick the next period length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            acc      <= '0;
            stretch  <= 1'b0;
            div_tick <= 1'b0;
        end else if (src_tick) begin
            if (terminal) begin
                cnt      <= '0;
                div_tick <= 1'b1;
                if (frac_en) begin
                    acc     <= sum[KW-1:0];
                    stretch <= sum[KW];
                end else begin
                    stretch <= 1'b0;
                end
            end else begin
                cnt      <= cnt + 1'b1;
                div_tick <= 1'b0;
            end
        end else begin
            div_tick <= 1'b0;
        end
    end

    // Counter never passes the longest legal period (R3)
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_N);
    // A divided tick only follows a source tick (R4)
    assert_tick_on_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |-> $past(src_tick));
    // The accumulator holds still while the fraction is off (R10)
    assert_acc_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frac_en |=> $stable(acc));
endmodule

// File: rtl/uart_frac_baud.sv
// Module: uart_frac_baud (top)
// Fractional baud generator: prescaler tap select, fractional divider and a
// mode stage that produces the 16x oversample tick and the bit tick.
// Assumes rst_n is synchronous and that settings change only between uses.
module uart_frac_baud
    import baudgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_sel,
    input  logic [3:0] div_n,
    input  logic [3:0] frac_k,
    input  logic       frac_en,
    input  logic       uart_mode,
    output logic       os_tick,
    output logic       bit_tick
);
    localparam int PH_W = $clog2(OS_RATIO);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OS_RATIO - 1);

    logic            src_tick;
    logic            div_tick;
    logic [PH_W-1:0] phase;
    logic            bit_hit;

    baud_prescale #(.NTAPS(TAP_COUNT), .CW(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tap_sel  (clk_sel),
        .src_tick (src_tick)
    );

    baud_frac_div #(.NW(DIV_W), .KW(FRAC_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .div_n    (div_n),
        .frac_k   (frac_k),
        .frac_en  (frac_en),
        .div_tick (div_tick)
    );

    // Bit boundary: 16th divided tick in UART mode, every 2nd in synchronous mode
    always_comb begin
        bit_hit = uart_mode ? (phase == PH_LAST) : phase[0];
    end

    // Track the divided-tick phase and register both output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= '0;
            os_tick  <= 1'b0;
            bit_tick <= 1'b0;
        end else begin
            os_tick  <= div_tick & uart_mode;
            bit_tick <= div_tick & bit_hit;
            if (div_tick) begin
                phase <= phase + 1'b1;
            end
        end
    end

    // In UART mode a bit tick coincides with an oversample tick (R8)
    assert_bit_with_os_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && $past(uart_mode)) |-> os_tick);
    // In synchronous mode the oversample tick is silent (R9)
    assert_no_os_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(uart_mode) |-> !os_tick);
    // Output pulses last a single cycle unless the source runs every clock (R4)
    assert_bit_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && $past(uart_mode)) |=> !bit_tick);
endmodule

// File: tb/sim_uart_frac_baud.sv
// Directed bench for uart_frac_baud: each task sets one configuration,
// measures tick spacing at the ports and checks it against the requirements.
module sim_uart_frac_baud;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_sel = '0;
    logic [3:0] div_n = 4'd1;
    logic [3:0] frac_k = '0;
    logic       frac_en = 1'b0;
    logic       uart_mode = 1'b1;
    logic       os_tick;
    logic       bit_tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    int per [0:31];

    uart_frac_baud u0 (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .div_n(div_n),
        .frac_k(frac_k), .frac_en(frac_en), .uart_mode(uart_mode),
        .os_tick(os_tick), .bit_tick(bit_tick)
    );

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Load a configuration under reset, check the reset outputs (R1), release
    task automatic setup(input logic [1:0] s, input logic [3:0] n,
                         input logic [3:0] k, input logic fe, input logic um);
        @(negedge clk);
        rst_n = 1'b0; clk_sel = s; div_n = n; frac_k = k; frac_en = fe; uart_mode = um;
        repeat (3) @(negedge clk);
        if (os_tick !== 1'b0 || bit_tick !== 1'b0) begin
            checks++; errors++;
            $display("FAIL R1: actual os=%0b bit=%0b expected 0 0", os_tick, bit_tick);
        end
        rst_n = 1'b1;
    endtask

    // Record n spacings of os_tick (which=0) or bit_tick (which=1), skipping start-up
    task automatic grab(input bit which, input int n);
        int seen = 0;
        int last = 0;
        int guard = 0;
        while (seen < n + 3 && guard < 20000) begin
            @(negedge clk);
            guard++;
            if ((which ? bit_tick : os_tick) === 1'b1) begin
                if (seen >= 3) per[seen-3] = cyc - last;
                last = cyc;
                seen++;
            end
        end
        if (seen < n + 3) begin
            for (int i = 0; i < n; i++) per[i] = -1;
        end
    endtask

    task automatic t_reset_state();
        setup(2'd0, 4'd1, 4'd0, 1'b0, 1'b1);
        // R1 also checked inside setup; one explicit check after release
        chk("R1 first cycle after release os", int'(os_tick), 0);
    endtask

    task automatic t_taps();
        for (int s = 0; s < 4; s++) begin
            int p;
            p = (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 8 : 32;
            setup(2'(s), 4'd3, 4'd0, 1'b0, 1'b1);
            grab(1'b0, 3);
            for (int i = 0; i < 3; i++) chk("R2 tap period", per[i], 3 * p);
        end
    endtask

    task automatic t_integer();
        setup(2'd1, 4'd5, 4'd0, 1'b0, 1'b1);
        grab(1'b0, 4);
        for (int i = 0; i < 4; i++) chk("R3 N=5 P=2", per[i], 10);
        setup(2'd0, 4'd0, 4'd0, 1'b0, 1'b1);
        grab(1'b0, 4);
        for (int i = 0; i < 4; i++) chk("R3 N=0 means 16", per[i], 16);
    endtask

    task automatic t_div_one();
        setup(2'd0, 4'd1, 4'd0, 1'b0, 1'b1);
        grab(1'b0, 8);
        for (int i = 0; i < 8; i++) chk("R4 N=1 P=1 every clock", per[i], 1);
        setup(2'd2, 4'd1, 4'd0, 1'b0, 1'b1);
        grab(1'b0, 4);
        for (int i = 0; i < 4; i++) chk("R4 N=1 P=8", per[i], 8);
    endtask

    // Sixteen periods: sum, per-period range and long count (R5)
    task automatic frac_case(input logic [1:0] s, input int p, input int n, input int k);
        int total = 0;
        int longs = 0;
        int bad = 0;
        setup(s, 4'(n), 4'(k), 1'b1, 1'b1);
        grab(1'b0, 16);
        for (int i = 0; i < 16; i++) begin
            total += per[i];
            if (per[i] == (n + 1) * p) longs++;
            else if (per[i] != n * p) bad++;
        end
        chk("R5 sixteen-period total", total, (16 * n + 16 - k) * p);
        chk("R5 long period count", longs, 16 - k);
        chk("R5 periods of other length", bad, 0);
    endtask

    task automatic t_fraction();
        frac_case(2'd0, 1, 4, 5);
        frac_case(2'd1, 2, 2, 13);
    endtask

    task automatic t_k_zero();
        setup(2'd0, 4'd1, 4'd0, 1'b1, 1'b1);
        grab(1'b0, 16);
        for (int i = 0; i < 16; i++) chk("R6 K=0 every period N+1", per[i], 2);
    endtask

    task automatic t_even();
        int adj = 0;
        int longs = 0;
        setup(2'd0, 4'd3, 4'd12, 1'b1, 1'b1);
        grab(1'b0, 32);
        for (int i = 0; i < 32; i++) begin
            if (per[i] == 4) longs++;
            if (i > 0 && per[i] == 4 && per[i-1] == 4) adj++;
        end
        chk("R7 no adjacent long periods", adj, 0);
        chk("R7 long count over 32 periods", longs, 8);
    endtask

    task automatic t_uart();
        int miss = 0;
        int guard = 0;
        int bits = 0;
        setup(2'd0, 4'd2, 4'd0, 1'b0, 1'b1);
        grab(1'b1, 3);
        for (int i = 0; i < 3; i++) chk("R8 bit period 16 x 2", per[i], 32);
        while (bits < 6 && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (bit_tick === 1'b1) begin
                bits++;
                if (os_tick !== 1'b1) miss++;
            end
        end
        chk("R8 bit tick coincides with os tick", miss, 0);
        chk("R8 bit ticks seen", bits, 6);
    endtask

    task automatic t_sync();
        int os_seen = 0;
        setup(2'd0, 4'd3, 4'd0, 1'b0, 1'b0);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (os_tick === 1'b1) os_seen++;
        end
        chk("R9 os tick silent in sync mode", os_seen, 0);
        grab(1'b1, 4);
        for (int i = 0; i < 4; i++) chk("R9 sync bit period 2 x 3", per[i], 6);
    endtask

    task automatic t_k_ignored();
        setup(2'd0, 4'd6, 4'd3, 1'b0, 1'b1);
        grab(1'b0, 16);
        for (int i = 0; i < 16; i++) chk("R10 K=3 ignored", per[i], 6);
        setup(2'd0, 4'd6, 4'd9, 1'b0, 1'b1);
        grab(1'b0, 16);
        for (int i = 0; i < 16; i++) chk("R10 K=9 ignored", per[i], 6);
    endtask

    initial begin
        t_reset_state();
        t_taps();
        t_integer();
        t_div_one();
        t_fraction();
        t_k_zero();
        t_even();
        t_uart();
        t_sync();
        t_k_ignored();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule